// File: doc/BRIEF.md
# Control transfer qualification filter

This block sits between instruction retirement and a transfer history buffer. For every retired control transfer it works out the 4-bit transfer type code and decides whether the transfer is recorded. The decision uses the privilege modes on both sides of the transfer, per-type inhibit bits, external-trap enables, freeze triggers, the frozen and debug conditions, and a return-stack emulation mode.

Jumps are classified by comparing their destination and source register numbers against the link registers x1 and x5. Each one becomes a call, a return, a co-routine swap, or a plain or linked jump. Traps and trap returns that cross privilege modes can be recorded in full, recorded with the source or target PC marked as zero, or dropped.

The result is registered and goes to the buffer as a one-cycle record strobe. The strobe comes with a push, pop or overwrite command. A separate one-cycle strobe tells the status logic to set the frozen flag.

Top module: `ctr_qual_filter`

## Requirements
- R1: The type code follows `kind_i` (0 exception, 1 interrupt, 2 trap return, 3 taken branch, 4 not-taken branch, 5 direct jump, 6 indirect jump, 7 no transfer). The codes are exception 1, interrupt 2, trap return 3, not-taken branch 4 and taken branch 5. Codes 0, 6 and 7 never appear with a record.
- R2: A direct jump is a direct call (9) when rd is x1 or x5, a direct jump (11) when rd is x0, and an other direct linked jump (15) otherwise. For an indirect jump the rules are checked in this order:
  - rd and rs1 are different link registers: co-routine swap (12).
  - rd is a link register: indirect call (8).
  - rs1 is a link register: return (13).
  - rd is x0: indirect jump (10).
  - otherwise: other indirect linked jump (14).
- R3: Control bit 32+type inhibits recording of that type. Bit 36 is the exception: it enables not-taken branches, which are recorded only when it is 1.
- R4: Privilege encoding is 0 U, 1 S, 3 M; value 2 counts as disabled. Control bits 0, 1 and 2 enable U, S and M. A branch or jump is recorded only when its source mode is enabled.
- R5: A trap between two enabled modes is recorded if not inhibited. A trap from a disabled mode into an enabled mode is recorded with `src_zero_o`=1 if not inhibited. A trap between two disabled modes is dropped.
- R6: A trap from an enabled mode into a disabled mode is an external trap. Into S it needs bit 8. Into M it needs bit 9, plus bit 8 when the source is U. It is recorded with `tgt_zero_o`=1 and the inhibit bits do not apply to it.
- R7: A trap return from an enabled mode is recorded if not inhibited, with `tgt_zero_o`=1 when the target mode is disabled. A trap return from a disabled mode is never recorded.
- R8: The set-frozen strobe is raised, and the trap is not recorded, in two cases:
  - an exception with cause 3 while bit 11 is 1;
  - an interrupt with cause 13 while bit 12 is 1.
- R9: With bit 7 set, return-stack emulation ignores inhibits and external enables. Calls (8, 9) push (`cmd_o`=0), returns (13) pop (1) and co-routine swaps (12) overwrite (2), all subject to the source-mode enable. Every other type is dropped. Outside this mode every record is a push.
- R10: No record is made while `frozen_i` or `debug_i` is 1. No set-frozen strobe is raised while `debug_i` is 1.
- R11: Outputs are registered. They appear one cycle after the retired transfer, last exactly one cycle, and are all zero after reset and whenever no record or freeze is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | A transfer retires this cycle |
| kind_i | input | 3 | Transfer kind (see R1) |
| rd_i | input | 5 | Jump destination register number |
| rs1_i | input | 5 | Jump source register number |
| src_priv_i | input | 2 | Source privilege mode |
| tgt_priv_i | input | 2 | Target privilege mode |
| cause_i | input | 6 | Trap cause code |
| debug_i | input | 1 | In debug mode, or transfer enters or leaves it |
| frozen_i | input | 1 | Recording frozen |
| ctl_i | input | 64 | Control word |
| rec_o | output | 1 | Record strobe |
| type_o | output | 4 | Transfer type code of the record |
| src_zero_o | output | 1 | Record source PC as zero |
| tgt_zero_o | output | 1 | Record target PC as zero |
| freeze_o | output | 1 | Set the frozen flag |
| cmd_o | output | 2 | Buffer command: 0 push, 1 pop, 2 overwrite |

## Verification
The block has no state beyond its output register, so any fault appears on the very next cycle. A wrong decision shows up as a missing or extra strobe, a wrong type code, a misplaced PC-zero flag or a wrong buffer command, and it never spreads to later transfers. The sweep covers every combination of mode enables, four filter patterns, the external-trap enables, the freeze enables and return-stack emulation. Under each combination it applies every kind, every source and target mode, and a set of link and non-link register pairs. A sticky or stuck output also shows on the idle cycle that follows.

// File: rtl/ctr_qual_filter.sv
module ctr_qual_filter #(
  parameter int CAUSE_W     = 6,
  parameter int BKPT_CAUSE  = 3,
  parameter int LCOFI_CAUSE = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [2:0]         kind_i,
  input  logic [4:0]         rd_i,
  input  logic [4:0]         rs1_i,
  input  logic [1:0]         src_priv_i,
  input  logic [1:0]         tgt_priv_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               debug_i,
  input  logic               frozen_i,
  input  logic [63:0]        ctl_i,
  output logic               rec_o,
  output logic [3:0]         type_o,
  output logic               src_zero_o,
  output logic               tgt_zero_o,
  output logic               freeze_o,
  output logic [1:0]         cmd_o
);
  localparam logic [1:0] PM_U = 2'd0, PM_S = 2'd1, PM_M = 2'd3;
  localparam logic [1:0] CMD_PUSH = 2'd0, CMD_POP = 2'd1, CMD_OVWR = 2'd2;

  logic ctl_unused;
  assign ctl_unused = ^{ctl_i[63:48], ctl_i[31:13], ctl_i[10], ctl_i[6:3]};

  logic src_en, tgt_en, rd_lk, rs1_lk, is_trap, is_tret, frz_hit, ext_ok, inh;
  logic [3:0] typ;

  assign src_en = (src_priv_i == PM_U && ctl_i[0]) || (src_priv_i == PM_S && ctl_i[1]) ||
                  (src_priv_i == PM_M && ctl_i[2]);
  assign tgt_en = (tgt_priv_i == PM_U && ctl_i[0]) || (tgt_priv_i == PM_S && ctl_i[1]) ||
                  (tgt_priv_i == PM_M && ctl_i[2]);
  assign rd_lk  = (rd_i == 5'd1) || (rd_i == 5'd5);
  assign rs1_lk = (rs1_i == 5'd1) || (rs1_i == 5'd5);
  assign is_trap = (kind_i == 3'd0) || (kind_i == 3'd1);
  assign is_tret = (kind_i == 3'd2);
  assign frz_hit = (kind_i == 3'd0 && cause_i == CAUSE_W'(BKPT_CAUSE) && ctl_i[11]) ||
                   (kind_i == 3'd1 && cause_i == CAUSE_W'(LCOFI_CAUSE) && ctl_i[12]);
  assign ext_ok = (tgt_priv_i == PM_M) ? (ctl_i[9] && (src_priv_i != PM_U || ctl_i[8])) :
                  (tgt_priv_i == PM_S) ? ctl_i[8] : 1'b0;

  always_comb begin
    case (kind_i)
      3'd0: typ = 4'd1;
      3'd1: typ = 4'd2;
      3'd2: typ = 4'd3;
      3'd3: typ = 4'd5;
      3'd4: typ = 4'd4;
      3'd5: typ = (rd_i == 5'd0) ? 4'd11 : (rd_lk ? 4'd9 : 4'd15);
      3'd6: begin
        if (rd_lk && rs1_lk && rd_i != rs1_i) typ = 4'd12;
        else if (rd_lk)                       typ = 4'd8;
        else if (rs1_lk)                      typ = 4'd13;
        else if (rd_i == 5'd0)                typ = 4'd10;
        else                                  typ = 4'd14;
      end
      default: typ = 4'd0;
    endcase
  end

  assign inh = (typ == 4'd4) ? !ctl_i[36] : ctl_i[{2'b10, typ}];

  logic rec_n, sz_n, tz_n;
  logic [1:0] cmd_n;

  always_comb begin
    rec_n = 1'b0;
    sz_n  = 1'b0;
    tz_n  = 1'b0;
    cmd_n = CMD_PUSH;
    if (valid_i && kind_i != 3'd7 && !frozen_i && !debug_i && !frz_hit) begin
      if (ctl_i[7]) begin
        if (src_en) begin
          case (typ)
            4'd8, 4'd9: rec_n = 1'b1;
            4'd13: begin rec_n = 1'b1; cmd_n = CMD_POP; end
            4'd12: begin rec_n = 1'b1; cmd_n = CMD_OVWR; end
            default: rec_n = 1'b0;
          endcase
        end
      end else if (is_trap) begin
        if (tgt_en) begin
          rec_n = !inh;
          sz_n  = !src_en;
        end else if (src_en) begin
          rec_n = ext_ok;
          tz_n  = 1'b1;
        end
      end else if (is_tret) begin
        rec_n = src_en && !inh;
        tz_n  = !tgt_en;
      end else begin
        rec_n = src_en && !inh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_o      <= 1'b0;
      type_o     <= 4'd0;
      src_zero_o <= 1'b0;
      tgt_zero_o <= 1'b0;
      freeze_o   <= 1'b0;
      cmd_o      <= CMD_PUSH;
    end else begin
      rec_o      <= rec_n;
      type_o     <= rec_n ? typ : 4'd0;
      src_zero_o <= rec_n && sz_n;
      tgt_zero_o <= rec_n && tz_n;
      freeze_o   <= valid_i && !debug_i && frz_hit;
      cmd_o      <= rec_n ? cmd_n : CMD_PUSH;
    end
  end

  a_r11_rec_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o |-> $past(valid_i));
  a_r10_blocked_no_rec: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o |-> $past(!frozen_i && !debug_i));
  a_r8_freeze_not_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> !rec_o);
  a_r1_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o |-> (type_o != 4'd0 && type_o != 4'd6 && type_o != 4'd7));
  a_r9_pop_is_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o && cmd_o == CMD_POP) |-> type_o == 4'd13);
  a_r5_src_zero_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    src_zero_o |-> (rec_o && (type_o == 4'd1 || type_o == 4'd2)));
  a_r7_tgt_zero_on_trap_or_ret: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_zero_o |-> (rec_o && type_o inside {4'd1, 4'd2, 4'd3}));
  a_r11_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o && !$past(valid_i, 1)) |-> 1'b0);
endmodule

// File: tb/ctr_qual_filter_tb.sv
module ctr_qual_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, debug_i = 1'b0, frozen_i = 1'b0;
  logic [2:0] kind_i = '0;
  logic [4:0] rd_i = '0, rs1_i = '0;
  logic [1:0] src_priv_i = '0, tgt_priv_i = '0;
  logic [5:0] cause_i = '0;
  logic [63:0] ctl_i = '0;
  logic rec_o, src_zero_o, tgt_zero_o, freeze_o;
  logic [3:0] type_o;
  logic [1:0] cmd_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_qual_filter dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i), .rd_i(rd_i),
    .rs1_i(rs1_i), .src_priv_i(src_priv_i), .tgt_priv_i(tgt_priv_i),
    .cause_i(cause_i), .debug_i(debug_i), .frozen_i(frozen_i), .ctl_i(ctl_i),
    .rec_o(rec_o), .type_o(type_o), .src_zero_o(src_zero_o),
    .tgt_zero_o(tgt_zero_o), .freeze_o(freeze_o), .cmd_o(cmd_o)
  );

  function automatic bit mode_on(logic [1:0] p, logic [63:0] c);
    case (p)
      2'd0: return c[0];
      2'd1: return c[1];
      2'd3: return c[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_link(logic [4:0] r);
    return r == 5'd1 || r == 5'd5;
  endfunction

  // R1 and R2 type codes
  function automatic logic [3:0] exp_type(logic [2:0] k, logic [4:0] rd, logic [4:0] rs);
    if (k == 3'd0) return 4'd1;
    if (k == 3'd1) return 4'd2;
    if (k == 3'd2) return 4'd3;
    if (k == 3'd3) return 4'd5;
    if (k == 3'd4) return 4'd4;
    if (k == 3'd5) begin
      if (is_link(rd)) return 4'd9;
      return (rd == 5'd0) ? 4'd11 : 4'd15;
    end
    if (k == 3'd6) begin
      if (is_link(rd)) return (is_link(rs) && rs != rd) ? 4'd12 : 4'd8;
      if (is_link(rs)) return 4'd13;
      return (rd == 5'd0) ? 4'd10 : 4'd14;
    end
    return 4'd0;
  endfunction

  task automatic apply(input bit v, input logic [2:0] k, input logic [4:0] rd,
                       input logic [4:0] rs, input logic [1:0] sp, input logic [1:0] tp,
                       input logic [5:0] cs, input bit dbg, input bit fr, input logic [63:0] c);
    bit e_rec, e_sz, e_tz, e_frz, se, te, inh, ext;
    logic [1:0] e_cmd;
    logic [3:0] t, e_typ;
    string tag;
    valid_i = v; kind_i = k; rd_i = rd; rs1_i = rs; src_priv_i = sp; tgt_priv_i = tp;
    cause_i = cs; debug_i = dbg; frozen_i = fr; ctl_i = c;
    t = exp_type(k, rd, rs);
    se = mode_on(sp, c); te = mode_on(tp, c);
    e_rec = 0; e_sz = 0; e_tz = 0; e_cmd = 2'd0;
    e_frz = v && !dbg && ((k == 3'd0 && cs == 6'd3 && c[11]) || (k == 3'd1 && cs == 6'd13 && c[12]));
    inh = (t == 4'd4) ? !c[36] : c[32 + int'(t)];
    ext = (tp == 2'd3) ? (c[9] && (sp != 2'd0 || c[8])) : (tp == 2'd1 && c[8]);
    if (!v || k == 3'd7 || dbg || fr) tag = "R10 R11";
    else if (e_frz) tag = "R8";
    else if (c[7]) tag = "R9";
    else if (k <= 3'd1) tag = "R5 R6 R3";
    else if (k == 3'd2) tag = "R7";
    else if (k >= 3'd5) tag = "R2 R4";
    else tag = "R1 R3 R4";
    if (v && k != 3'd7 && !dbg && !fr && !e_frz) begin
      if (c[7]) begin
        if (se && (t == 4'd8 || t == 4'd9)) e_rec = 1;
        if (se && t == 4'd13) begin e_rec = 1; e_cmd = 2'd1; end
        if (se && t == 4'd12) begin e_rec = 1; e_cmd = 2'd2; end
      end else if (k <= 3'd1) begin
        if (se && te) e_rec = !inh;
        else if (!se && te) begin e_rec = !inh; e_sz = e_rec; end
        else if (se && !te) begin e_rec = ext; e_tz = e_rec; end
      end else if (k == 3'd2) begin
        e_rec = se && !inh;
        e_tz = e_rec && !te;
      end else e_rec = se && !inh;
    end
    e_typ = e_rec ? t : 4'd0;
    @(negedge clk);
    checks++;
    if (rec_o !== e_rec || type_o !== e_typ || src_zero_o !== e_sz || tgt_zero_o !== e_tz ||
        freeze_o !== e_frz || cmd_o !== e_cmd) begin
      errors++;
      $display("FAIL %s k=%0d rd=%0d rs1=%0d sp=%0d tp=%0d cause=%0d ctl=%h actual rec=%b typ=%0d sz=%b tz=%b frz=%b cmd=%0d expected rec=%b typ=%0d sz=%b tz=%b frz=%b cmd=%0d",
               tag, k, rd, rs, sp, tp, cs, c, rec_o, type_o, src_zero_o, tgt_zero_o, freeze_o,
               cmd_o, e_rec, e_typ, e_sz, e_tz, e_frz, e_cmd);
    end
  endtask

  task automatic sweep(input logic [63:0] c, input bit dbg, input bit fr);
    logic [1:0] modes [3] = '{2'd0, 2'd1, 2'd3};
    logic [4:0] regs [4] = '{5'd0, 5'd1, 5'd5, 5'd7};
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 3; d++) begin
        apply(1, 3'd0, 0, 0, modes[s], modes[d], 6'd3, dbg, fr, c);
        apply(1, 3'd0, 0, 0, modes[s], modes[d], 6'd2, dbg, fr, c);
        apply(1, 3'd1, 0, 0, modes[s], modes[d], 6'd13, dbg, fr, c);
        apply(1, 3'd1, 0, 0, modes[s], modes[d], 6'd7, dbg, fr, c);
        apply(1, 3'd2, 0, 0, modes[s], modes[d], 6'd0, dbg, fr, c);
      end
      apply(1, 3'd3, 0, 0, modes[s], modes[s], 6'd0, dbg, fr, c);
      apply(1, 3'd4, 0, 0, modes[s], modes[s], 6'd0, dbg, fr, c);
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          apply(1, 3'd5, regs[a], regs[b], modes[s], modes[s], 6'd0, dbg, fr, c);
          apply(1, 3'd6, regs[a], regs[b], modes[s], modes[s], 6'd0, dbg, fr, c);
        end
    end
    apply(1, 3'd7, 0, 0, 2'd3, 2'd3, 6'd0, dbg, fr, c);
    apply(0, 3'd6, 5'd1, 5'd7, 2'd3, 2'd3, 6'd0, dbg, fr, c);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL R11 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] filt [4] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A};
    logic [63:0] c;
    repeat (3) @(negedge clk);
    checks++; // R11 reset state
    if (rec_o !== 0 || type_o !== 0 || src_zero_o !== 0 || tgt_zero_o !== 0 ||
        freeze_o !== 0 || cmd_o !== 0) begin
      errors++;
      $display("FAIL R11 reset actual rec=%b typ=%0d frz=%b expected all zero", rec_o, type_o, freeze_o);
    end
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int f = 0; f < 4; f++)
        for (int te = 0; te < 4; te++)
          for (int ras = 0; ras < 2; ras++)
            for (int fz = 0; fz < 2; fz++) begin
              c = '0;
              c[2:0] = 3'(p);
              c[47:32] = filt[f];
              c[9:8] = 2'(te);
              c[7] = ras[0];
              c[12:11] = fz[0] ? 2'b11 : 2'b00;
              sweep(c, 1'b0, 1'b0);
            end
    c = '0; c[2:0] = 3'b111; c[12:11] = 2'b11; c[9:8] = 2'b11;
    sweep(c, 1'b0, 1'b1); // R10 frozen
    sweep(c, 1'b1, 1'b0); // R10 debug
    c[7] = 1'b1;
    sweep(c, 1'b0, 1'b1); // R10 frozen with R9 mode
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule